// File: doc/BRIEF.md
# Write protection sequencer

This block stands between a host write bus and the page-load logic of a byte-wide nonvolatile memory. It watches every write the host makes, filters out strobes too short to count, and decides whether each accepted write may reach the page-load logic. A permitted write produces a one-cycle `wrPermit` pulse. The block also reports whether protection is armed.

Specific key writes, each a fixed data byte at a fixed low-16-bit address, change the protection. Three keys in a row open a write window. If protection was off, the same three keys also arm it, once the window has closed and a programming interval has passed. A longer chain of six keys turns protection off after the same interval. While protection is armed, a write goes through only inside a window opened by the three-key prefix. The armed flag survives the soft reset and is cleared only by the power-on reset. This models a flag held in nonvolatile storage.

Top module: `wr_lock_seq`

## Requirements
- R1: A write is accepted when `wrStrobe` has been high for at least `MinPulse` consecutive rising clock edges and is then sampled low. Its address and data are the values sampled at the last edge where the strobe was high. A shorter high pulse is ignored completely: it gives no permit and does not move the key matcher.
- R2: For a permitted write, `wrPermit` is high for exactly one cycle, set by the clock edge that first samples the strobe low.
- R3: With protection off and no programming interval running, every accepted write is permitted, including the key writes.
- R4: With protection on, an accepted write outside an open window is not permitted, including the key writes.
- R5: Three accepted writes in order open the window: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Every accepted write inside the window is permitted, and each one restarts the window timer.
- R6: The window closes once `WinCycles` clock edges have passed after its last accepted write with no further accepted write. A programming interval then starts. `ProgCycles` edges later, `protOn` goes to 1.
- R7: Six accepted writes in order turn protection off: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. The sixth write starts a programming interval, and `ProgCycles` edges later `protOn` goes to 0.
- R8: Any accepted write that does not match the expected next key returns the matcher to its start. That write is judged only against the current protection state, so a broken chain must be restarted from its first key.
- R9: During a programming interval, accepted writes are never permitted and do not advance the matcher.
- R10: `protOn` is cleared only by `porN`. A soft reset (`rstN` low) returns the matcher to its start, closes any window and abandons any running interval, but it keeps `protOn`.
- R11: After a power-on reset, `protOn` and `wrPermit` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, async; clears everything |
| rstN | input | 1 | Soft reset, active low, async; keeps protection flag |
| wrStrobe | input | 1 | Host write strobe level, active high |
| wrAddr | input | 16 | Low 16 address bits of the host write |
| wrData | input | 8 | Host write data |
| wrPermit | output | 1 | One-cycle pulse: accepted write may go to page load |
| protOn | output | 1 | Protection armed |

## Verification
The assertions assume that `wrStrobe` is held steady between clock edges, so a write is recognised only from the levels sampled at each edge. They also assume that the two resets are the only way the flag or the sequencer state changes outside the modelled transitions. The stimulus changes inputs only on falling clock edges. Each strobe lasts a whole number of cycles, and the one-cycle pulses are there on purpose to probe the filter. Window gaps are kept well below `WinCycles`, except where a test waits on purpose for the window to close.

// File: rtl/wr_lock_pkg.sv
package wr_lock_pkg;

  localparam int CMD_AW = 16;
  localparam int CMD_DW = 8;
  localparam int KEY_W  = CMD_AW + CMD_DW;
  localparam int KEY_N  = 5;

  // key index: 0 AA@5555, 1 55@2AAA, 2 A0@5555, 3 80@5555, 4 20@5555
  localparam logic [KEY_N-1:0][KEY_W-1:0] KEY_TAB = {
    {16'h5555, 8'h20},
    {16'h5555, 8'h80},
    {16'h5555, 8'hA0},
    {16'h2AAA, 8'h55},
    {16'h5555, 8'hAA}
  };

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_K1, SEQ_K2, SEQ_D3, SEQ_D4, SEQ_D5, SEQ_WIN, SEQ_BUSY
  } seqState_t;

  typedef struct packed {
    logic winRestart;
    logic progStart;
  } ctlStrobe_t;

  typedef struct packed {
    logic accept;
    logic keyAa;
    logic key55;
    logic keyOpen;
    logic keyErase;
    logic keyOff;
    logic winExpire;
    logic progDone;
  } dpFlags_t;

endpackage

// File: rtl/wr_lock_dp.sv
module wr_lock_dp
  import wr_lock_pkg::*;
#(
  parameter int MinPulse   = 2,
  parameter int WinCycles  = 16,
  parameter int ProgCycles = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [CMD_AW-1:0] wrAddr,
  input  logic [CMD_DW-1:0] wrData,
  input  ctlStrobe_t        ctl,
  output dpFlags_t          flags
);

  localparam int PulseW = $clog2(MinPulse + 1);
  localparam int WinW   = (WinCycles > 1) ? $clog2(WinCycles) : 1;
  localparam int ProgW  = (ProgCycles > 1) ? $clog2(ProgCycles) : 1;
  localparam logic [PulseW-1:0] PulseFull = PulseW'(MinPulse);
  localparam logic [WinW-1:0]   WinLast   = WinW'(WinCycles - 1);
  localparam logic [ProgW-1:0]  ProgLast  = ProgW'(ProgCycles - 1);

  logic [PulseW-1:0] hiCnt;
  logic [CMD_AW-1:0] addrQ;
  logic [CMD_DW-1:0] dataQ;
  logic [WinW-1:0]   winCnt;
  logic [ProgW-1:0]  progCnt;
  logic [KEY_N-1:0]  keyHit;

  // strobe width filter and capture of the last high sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (wrStrobe) begin
      if (hiCnt != PulseFull) hiCnt <= hiCnt + 1'b1;
      addrQ <= wrAddr;
      dataQ <= wrData;
    end else begin
      hiCnt <= '0;
    end
  end

  // window and programming timers, restarted by control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      progCnt <= '0;
    end else begin
      if (ctl.winRestart)      winCnt <= '0;
      else if (winCnt != WinLast) winCnt <= winCnt + 1'b1;
      if (ctl.progStart)       progCnt <= '0;
      else if (progCnt != ProgLast) progCnt <= progCnt + 1'b1;
    end
  end

  for (genvar k = 0; k < KEY_N; k++) begin : g_key
    assign keyHit[k] = ({addrQ, dataQ} == KEY_TAB[k]);
  end

  always_comb begin
    flags.accept    = !wrStrobe && (hiCnt == PulseFull);
    flags.keyAa     = keyHit[0];
    flags.key55     = keyHit[1];
    flags.keyOpen   = keyHit[2];
    flags.keyErase  = keyHit[3];
    flags.keyOff    = keyHit[4];
    flags.winExpire = (winCnt == WinLast);
    flags.progDone  = (progCnt == ProgLast);
  end

endmodule

// File: rtl/wr_lock_ctl.sv
module wr_lock_ctl
  import wr_lock_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  dpFlags_t   flags,
  output ctlStrobe_t ctl,
  output seqState_t  seqState,
  output logic       wrPermit,
  output logic       protOn
);

  seqState_t nxtState;
  logic      pendOn, pendNxt, permitNxt;

  always_comb begin
    nxtState = seqState;
    pendNxt  = pendOn;
    ctl      = '0;
    unique case (seqState)
      SEQ_IDLE: if (flags.accept && flags.keyAa) nxtState = SEQ_K1;
      SEQ_K1: if (flags.accept) nxtState = flags.key55 ? SEQ_K2 : SEQ_IDLE;
      SEQ_K2: if (flags.accept) begin
        if (flags.keyOpen) begin
          nxtState       = SEQ_WIN;
          ctl.winRestart = 1'b1;
        end else if (flags.keyErase) begin
          nxtState = SEQ_D3;
        end else begin
          nxtState = SEQ_IDLE;
        end
      end
      SEQ_D3: if (flags.accept) nxtState = flags.keyAa ? SEQ_D4 : SEQ_IDLE;
      SEQ_D4: if (flags.accept) nxtState = flags.key55 ? SEQ_D5 : SEQ_IDLE;
      SEQ_D5: if (flags.accept) begin
        if (flags.keyOff) begin
          nxtState      = SEQ_BUSY;
          ctl.progStart = 1'b1;
          pendNxt       = 1'b0;
        end else begin
          nxtState = SEQ_IDLE;
        end
      end
      SEQ_WIN: begin
        if (flags.accept) begin
          ctl.winRestart = 1'b1;
        end else if (flags.winExpire) begin
          nxtState      = SEQ_BUSY;
          ctl.progStart = 1'b1;
          pendNxt       = 1'b1;
        end
      end
      SEQ_BUSY: if (flags.progDone) nxtState = SEQ_IDLE;
      default: nxtState = SEQ_IDLE;
    endcase
    permitNxt = flags.accept &&
                ((seqState == SEQ_WIN) || ((seqState != SEQ_BUSY) && !protOn));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SEQ_IDLE;
      pendOn   <= 1'b0;
      wrPermit <= 1'b0;
    end else begin
      seqState <= nxtState;
      pendOn   <= pendNxt;
      wrPermit <= permitNxt;
    end
  end

  // nonvolatile flag: only the power-on reset clears it
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                       protOn <= 1'b0;
    else if (seqState == SEQ_BUSY && flags.progDone) protOn <= pendOn;
  end

endmodule

// File: rtl/wr_lock_seq.sv
module wr_lock_seq
  import wr_lock_pkg::*;
#(
  parameter int MinPulse   = 2,
  parameter int WinCycles  = 16,
  parameter int ProgCycles = 32
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rstN,
  input  logic        wrStrobe,
  input  logic [15:0] wrAddr,
  input  logic [7:0]  wrData,
  output logic        wrPermit,
  output logic        protOn
);

  logic       softRstN;
  ctlStrobe_t ctl;
  dpFlags_t   flags;
  seqState_t  seqState;

  assign softRstN = porN & rstN;

  wr_lock_dp #(
    .MinPulse(MinPulse), .WinCycles(WinCycles), .ProgCycles(ProgCycles)
  ) u_dp (
    .clk(clk), .rstN(softRstN), .wrStrobe(wrStrobe),
    .wrAddr(wrAddr), .wrData(wrData), .ctl(ctl), .flags(flags)
  );

  wr_lock_ctl u_ctl (
    .clk(clk), .porN(porN), .rstN(softRstN), .flags(flags), .ctl(ctl),
    .seqState(seqState), .wrPermit(wrPermit), .protOn(protOn)
  );

endmodule

// File: rtl/wr_lock_chk.sv
module wr_lock_chk
  import wr_lock_pkg::*;
(
  input logic      clk,
  input logic      porN,
  input logic      rstN,
  input logic      wrStrobe,
  input logic      wrPermit,
  input logic      protOn,
  input seqState_t seqState
);

  AST_PERMIT_AFTER_FALL: assert property (@(posedge clk) disable iff (!porN || !rstN)
    wrPermit |-> (!$past(wrStrobe) && $past(wrStrobe, 2))); // R2

  AST_PERMIT_SINGLE: assert property (@(posedge clk) disable iff (!porN || !rstN)
    wrPermit |=> !wrPermit); // R2

  AST_LOCKED_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (wrPermit && protOn) |-> ($past(seqState) == SEQ_WIN)); // R4

  AST_WINDOW_ENTRY: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (seqState == SEQ_WIN && $past(seqState) != SEQ_WIN) |-> ($past(seqState) == SEQ_K2)); // R5

  AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (seqState == SEQ_BUSY && $past(seqState) != SEQ_BUSY)
      |-> ($past(seqState) == SEQ_WIN || $past(seqState) == SEQ_D5)); // R7

  AST_FLAG_FROM_PROG: assert property (@(posedge clk) disable iff (!porN || !rstN)
    !$stable(protOn) |-> ($past(seqState) == SEQ_BUSY)); // R6

  AST_PROG_BLOCKS: assert property (@(posedge clk) disable iff (!porN || !rstN)
    ($past(seqState) == SEQ_BUSY) |-> !wrPermit); // R9

endmodule

bind wr_lock_seq wr_lock_chk chk (
  .clk(clk), .porN(porN), .rstN(rstN), .wrStrobe(wrStrobe),
  .wrPermit(wrPermit), .protOn(protOn), .seqState(seqState)
);

// File: tb/wr_lock_seq_test.sv
module wr_lock_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MIN  = 2;
  localparam int WIN  = 16;
  localparam int PROG = 32;
  localparam int S_IDLE = 0, S_K1 = 1, S_K2 = 2, S_D3 = 3, S_D4 = 4, S_D5 = 5,
                 S_WIN = 6, S_BUSY = 7;

  logic clk = 1'b0;
  logic porN = 1'b0, rstN = 1'b0, wrStrobe = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic wrPermit, protOn;

  int vectors = 0, fails = 0;
  bit running = 0;
  string curReq = "R11";

  // reference model state
  int mSt = S_IDLE, hiRun = 0, winAge = 0, progAge = 0;
  bit mProt = 0, mPermit = 0, pend = 0, acc;
  bit [15:0] mA = 0;
  bit [7:0]  mD = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_lock_seq #(.MinPulse(MIN), .WinCycles(WIN), .ProgCycles(PROG)) uut (
    .clk(clk), .porN(porN), .rstN(rstN), .wrStrobe(wrStrobe),
    .wrAddr(wrAddr), .wrData(wrData), .wrPermit(wrPermit), .protOn(protOn)
  );

  function automatic bit hit(input bit [15:0] a, input bit [7:0] d);
    return (mA == a) && (mD == d);
  endfunction

  task automatic softClr();
    mSt = S_IDLE; hiRun = 0; winAge = 0; progAge = 0;
    mPermit = 0; pend = 0; mA = 0; mD = 0;
  endtask

  always @(posedge clk) begin
    if (!porN) begin
      mProt = 0; softClr();
    end else if (!rstN) begin
      softClr();
    end else begin
      acc = !wrStrobe && (hiRun >= MIN);
      mPermit = acc && (mSt == S_WIN || (mSt != S_BUSY && !mProt));
      case (mSt)
        S_IDLE: if (acc && hit(16'h5555, 8'hAA)) mSt = S_K1;
        S_K1: if (acc) mSt = hit(16'h2AAA, 8'h55) ? S_K2 : S_IDLE;
        S_K2: if (acc) begin
          if (hit(16'h5555, 8'hA0)) begin mSt = S_WIN; winAge = 0; end
          else if (hit(16'h5555, 8'h80)) mSt = S_D3;
          else mSt = S_IDLE;
        end
        S_D3: if (acc) mSt = hit(16'h5555, 8'hAA) ? S_D4 : S_IDLE;
        S_D4: if (acc) mSt = hit(16'h2AAA, 8'h55) ? S_D5 : S_IDLE;
        S_D5: if (acc) begin
          if (hit(16'h5555, 8'h20)) begin mSt = S_BUSY; progAge = 0; pend = 0; end
          else mSt = S_IDLE;
        end
        S_WIN: begin
          if (acc) winAge = 0;
          else if (winAge == WIN - 1) begin mSt = S_BUSY; progAge = 0; pend = 1; end
          else winAge++;
        end
        default: begin
          if (progAge == PROG - 1) begin mProt = pend; mSt = S_IDLE; end
          else progAge++;
        end
      endcase
      if (wrStrobe) begin hiRun++; mA = wrAddr; mD = wrData; end
      else hiRun = 0;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      vectors++;
      if (wrPermit !== mPermit || protOn !== mProt) begin
        fails++;
        $display("FAIL %s: wrPermit=%b expected %b, protOn=%b expected %b at %0t",
                 curReq, wrPermit, mPermit, protOn, mProt, $time);
      end
    end
  end

  task automatic expectProt(input bit exp, input string req);
    @(negedge clk);
    vectors++;
    if (protOn !== exp) begin
      fails++;
      $display("FAIL %s: protOn=%b expected %b", req, protOn, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input int len);
    @(negedge clk);
    wrAddr = a; wrData = d; wrStrobe = 1'b1;
    repeat (len) @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic openKeys();
    wr(16'h5555, 8'hAA, MIN); wr(16'h2AAA, 8'h55, MIN); wr(16'h5555, 8'hA0, MIN);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    summary();
  end

  initial begin
    idle(3);
    running = 1;
    curReq = "R11";
    expectProt(1'b0, "R11");
    porN = 1'b1; rstN = 1'b1;
    idle(2);

    curReq = "R3";   // ordinary and key writes pass while unprotected
    wr(16'h0100, 8'h11, MIN);
    wr(16'h0101, 8'h22, MIN + 2);
    curReq = "R1";   // short pulse ignored
    wr(16'h0102, 8'h33, MIN - 1);
    idle(2);

    curReq = "R5";   // arm: open window, load page bytes
    openKeys();
    wr(16'h0200, 8'h44, MIN); wr(16'h0201, 8'h55, MIN); wr(16'h0202, 8'h66, MIN);
    curReq = "R6";
    idle(WIN + PROG + 4);
    expectProt(1'b1, "R6");

    curReq = "R4";   // plain and key writes blocked when armed
    wr(16'h0300, 8'h77, MIN);
    wr(16'h5555, 8'hAA, MIN);
    wr(16'h1234, 8'h00, MIN);
    idle(2);

    curReq = "R5";   // authorised page write
    openKeys();
    wr(16'h0400, 8'h01, MIN); wr(16'h0401, 8'h02, MIN + 1);
    idle(WIN + PROG + 4);
    expectProt(1'b1, "R5");

    curReq = "R8";   // broken chain then the last key alone
    wr(16'h5555, 8'hAA, MIN); wr(16'h2AAA, 8'h55, MIN);
    wr(16'h1234, 8'h12, MIN);
    wr(16'h5555, 8'hA0, MIN);
    wr(16'h0500, 8'h09, MIN);
    idle(WIN + 4);

    curReq = "R1";   // a short pulse inside the chain does not break it
    wr(16'h5555, 8'hAA, MIN); wr(16'h7777, 8'h00, MIN - 1);
    wr(16'h2AAA, 8'h55, MIN); wr(16'h5555, 8'hA0, MIN);
    wr(16'h0600, 8'h5A, MIN);
    curReq = "R9";   // writes during the programming interval
    idle(WIN + 2);
    openKeys();
    wr(16'h0601, 8'h5B, MIN);
    idle(PROG + 4);
    expectProt(1'b1, "R9");

    curReq = "R10";  // soft reset keeps the flag, closes the window
    openKeys();
    @(negedge clk); rstN = 1'b0;
    idle(2); rstN = 1'b1;
    wr(16'h0700, 8'hEE, MIN);
    expectProt(1'b1, "R10");
    idle(2);

    curReq = "R7";   // six-key disable
    wr(16'h5555, 8'hAA, MIN); wr(16'h2AAA, 8'h55, MIN); wr(16'h5555, 8'h80, MIN);
    wr(16'h5555, 8'hAA, MIN); wr(16'h2AAA, 8'h55, MIN); wr(16'h5555, 8'h20, MIN);
    idle(PROG + 4);
    expectProt(1'b0, "R7");
    curReq = "R3";
    wr(16'h0800, 8'hC3, MIN);
    idle(2);

    curReq = "R10";  // re-arm, then only the power-on reset clears it
    openKeys();
    idle(WIN + PROG + 4);
    expectProt(1'b1, "R10");
    @(negedge clk); porN = 1'b0;
    curReq = "R11";
    idle(2);
    expectProt(1'b0, "R11");
    porN = 1'b1;
    wr(16'h0900, 8'h3C, MIN);
    idle(3);
    summary();
  end
endmodule